// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the processor's condition flags in a 4-bit register: a carry/borrow flag, a branch flag and an interrupt-enable flag, plus one reserved bit that always reads zero. After each completed ALU operation, the ALU reports the operation class and the carry and branch values it produced. The block then updates each flag according to its own rule for that class. Logic operations update only the branch flag. Arithmetic operations and shift/rotate operations update both carry and branch. The current carry is also fed back to the shifter, where it acts as the fifth bit shifted in or out.

Direct commands can also change the flags. One sets branch and carry together, one toggles branch, and one loads the whole register from the data path. The interrupt enable has its own commands: one clears it, and two others (enable and sleep) set it. The interrupt enable is cleared by reset and by the disable command. Apart from a whole-register load, it becomes set again only through the enable or sleep command. When a command and an ALU update touch the same flag in one cycle, the command wins.

The ALU update is a single-cycle strobe with no back-pressure: the register accepts an update on every cycle, so there is no ready signal. All pins are plain control and status signals. Every change takes effect at the next rising clock edge.

Top module: `cond_flag_reg`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, `ccr_q` is 4'b0000 and `irq_allow` is 0.
- R2: `ccr_q` has carry in bit 0, branch in bit 1 and interrupt enable in bit 3. Bit 2 is always read as 0, even after a load that writes 1 to it.
- R3: With `alu_valid` high and `alu_class` = 2'b00 (arithmetic), carry takes `alu_carry` and branch takes `alu_branch` at the next edge.
- R4: With `alu_valid` high and `alu_class` = 2'b01 (logic), branch takes `alu_branch` and carry keeps its value.
- R5: With `alu_valid` high and `alu_class` = 2'b10 (shift/rotate), carry and branch both take the ALU values. `shift_carry_in` always equals the stored carry.
- R6: `alu_class` = 2'b11, or `alu_valid` low, changes no flag.
- R7: `cmd_set_bc` sets carry and branch to 1, overriding an ALU update in the same cycle.
- R8: `cmd_tog_b` inverts the stored branch flag and overrides the ALU's branch value. Carry still follows an ALU update in the same cycle.
- R9: `cmd_load` writes `load_data` into the register and overrides every other command and ALU update in that cycle.
- R10: `cmd_di` clears interrupt enable, and it wins over `cmd_ei` or `cmd_sleep` in the same cycle.
- R11: Without a load, interrupt enable becomes 1 only through `cmd_ei` or `cmd_sleep`. ALU updates and branch/carry commands never set it.
- R12: `irq_allow` equals the interrupt-enable flag.
- R13: When `cmd_set_bc` and `cmd_tog_b` arrive together, branch ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | ALU operation completed this cycle |
| alu_class | input | 2 | 00 arithmetic, 01 logic, 10 shift/rotate, 11 none |
| alu_carry | input | 1 | Carry/borrow produced by the ALU |
| alu_branch | input | 1 | Branch condition produced by the ALU |
| cmd_set_bc | input | 1 | Set branch and carry |
| cmd_tog_b | input | 1 | Toggle branch |
| cmd_load | input | 1 | Load the whole register |
| load_data | input | 4 | Value for the load command |
| cmd_di | input | 1 | Disable interrupts |
| cmd_ei | input | 1 | Enable interrupts |
| cmd_sleep | input | 1 | Sleep; also enables interrupts |
| ccr_q | output | 4 | Full register {ie, 0, branch, carry} |
| flag_c | output | 1 | Carry/borrow flag |
| flag_b | output | 1 | Branch flag |
| flag_ie | output | 1 | Interrupt-enable flag |
| irq_allow | output | 1 | Interrupt requests may be accepted |
| shift_carry_in | output | 1 | Carry fed to the shifter as fifth bit |

## Verification
The assertions check several rules on every cycle:
- Interrupt enable never rises without an enable, sleep or load command in the previous cycle.
- The disable command always leaves it clear.
- A logic operation with no carry command leaves carry stable.
- Set-branch-and-carry always yields both flags set.
- An idle cycle changes nothing.

Other behaviours can only be shown by the bench's directed scenarios:
- The exact values the ALU writes for each operation class.
- The toggle acting against the stored branch value while carry still follows the ALU.
- The order of precedence when several commands collide.
- The reserved bit being dropped on a load.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int unsigned CCR_W = 4;
  localparam int unsigned CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    OP_ARITH = 2'b00,
    OP_LOGIC = 2'b01,
    OP_SHIFT = 2'b10,
    OP_NONE  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic ie;
    logic rsv;
    logic b;
    logic c;
  } ccr_t;
endpackage

// File: rtl/cfr_alu_rule.sv
module cfr_alu_rule
  import cfr_pkg::*;
(
  input  logic             valid,
  input  logic [CLS_W-1:0] op_class,
  input  logic             carry_in,
  input  logic             branch_in,
  output logic             c_we,
  output logic             c_val,
  output logic             b_we,
  output logic             b_val
);
  op_class_e cls;
  assign cls = op_class_e'(op_class);

  always_comb begin
    c_we = 1'b0;
    b_we = 1'b0;
    if (valid) begin
      unique case (cls)
        OP_ARITH, OP_SHIFT: begin
          c_we = 1'b1;
          b_we = 1'b1;
        end
        OP_LOGIC: b_we = 1'b1;
        default: ;
      endcase
    end
  end

  assign c_val = carry_in;
  assign b_val = branch_in;
endmodule

// File: rtl/cfr_cmd_merge.sv
module cfr_cmd_merge
  import cfr_pkg::*;
(
  input  ccr_t             cur,
  input  logic             c_we,
  input  logic             c_val,
  input  logic             b_we,
  input  logic             b_val,
  input  logic             set_bc,
  input  logic             tog_b,
  input  logic             load,
  input  logic [CCR_W-1:0] load_val,
  input  logic             di,
  input  logic             ei,
  input  logic             sleep,
  output ccr_t             nxt
);
  always_comb begin
    nxt     = cur;
    nxt.rsv = 1'b0;
    // ALU rules first; commands below take precedence per flag
    if (c_we) nxt.c = c_val;
    if (b_we) nxt.b = b_val;
    if (set_bc) begin
      nxt.c = 1'b1;
      nxt.b = 1'b1;
    end else if (tog_b) begin
      nxt.b = ~cur.b;
    end
    if (di)              nxt.ie = 1'b0;
    else if (ei | sleep) nxt.ie = 1'b1;
    // whole-register load overrides everything
    if (load) begin
      nxt     = ccr_t'(load_val);
      nxt.rsv = 1'b0;
    end
  end
endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_valid,
  input  logic [CLS_W-1:0] alu_class,
  input  logic             alu_carry,
  input  logic             alu_branch,
  input  logic             cmd_set_bc,
  input  logic             cmd_tog_b,
  input  logic             cmd_load,
  input  logic [CCR_W-1:0] load_data,
  input  logic             cmd_di,
  input  logic             cmd_ei,
  input  logic             cmd_sleep,
  output logic [CCR_W-1:0] ccr_q,
  output logic             flag_c,
  output logic             flag_b,
  output logic             flag_ie,
  output logic             irq_allow,
  output logic             shift_carry_in
);
  ccr_t q, d;
  logic c_we, c_val, b_we, b_val;

  cfr_alu_rule u_rule (
    .valid(alu_valid), .op_class(alu_class),
    .carry_in(alu_carry), .branch_in(alu_branch),
    .c_we(c_we), .c_val(c_val), .b_we(b_we), .b_val(b_val)
  );

  cfr_cmd_merge u_merge (
    .cur(q), .c_we(c_we), .c_val(c_val), .b_we(b_we), .b_val(b_val),
    .set_bc(cmd_set_bc), .tog_b(cmd_tog_b), .load(cmd_load),
    .load_val(load_data), .di(cmd_di), .ei(cmd_ei), .sleep(cmd_sleep),
    .nxt(d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign ccr_q          = q;
  assign flag_c         = q.c;
  assign flag_b         = q.b;
  assign flag_ie        = q.ie;
  assign irq_allow      = q.ie;
  assign shift_carry_in = q.c;

  // R11: interrupt enable only rises after enable, sleep or load
  a_r11_ie_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ie) |-> $past(cmd_ei | cmd_sleep | cmd_load));

  // R10: disable command without load leaves interrupts off
  a_r10_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_di && !cmd_load) |=> !flag_ie);

  // R4: logic operation keeps carry
  a_r4_logic_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_class == 2'b01 && !cmd_set_bc && !cmd_load) |=> $stable(flag_c));

  // R7: set branch and carry
  a_r7_set_bc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set_bc && !cmd_load) |=> (flag_c && flag_b));

  // R6: idle cycle holds the register
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alu_valid && alu_class != 2'b11) && !cmd_set_bc && !cmd_tog_b && !cmd_load
     && !cmd_di && !cmd_ei && !cmd_sleep) |=> $stable(ccr_q));
endmodule

// File: tb/cond_flag_reg_bench.sv
module cond_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid, alu_carry, alu_branch;
  logic [1:0] alu_class;
  logic       cmd_set_bc, cmd_tog_b, cmd_load, cmd_di, cmd_ei, cmd_sleep;
  logic [3:0] load_data;
  logic [3:0] ccr_q;
  logic       flag_c, flag_b, flag_ie, irq_allow, shift_carry_in;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  cond_flag_reg u_cond_flag_reg (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_class(alu_class),
    .alu_carry(alu_carry), .alu_branch(alu_branch), .cmd_set_bc(cmd_set_bc),
    .cmd_tog_b(cmd_tog_b), .cmd_load(cmd_load), .load_data(load_data),
    .cmd_di(cmd_di), .cmd_ei(cmd_ei), .cmd_sleep(cmd_sleep), .ccr_q(ccr_q),
    .flag_c(flag_c), .flag_b(flag_b), .flag_ie(flag_ie), .irq_allow(irq_allow),
    .shift_carry_in(shift_carry_in)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_valid = 0; alu_class = 2'b11; alu_carry = 0; alu_branch = 0;
    cmd_set_bc = 0; cmd_tog_b = 0; cmd_load = 0; load_data = 0;
    cmd_di = 0; cmd_ei = 0; cmd_sleep = 0;
  endtask

  // apply the driven inputs for one edge, then return to idle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic alu(input logic [1:0] cls, input logic c, input logic b);
    alu_valid = 1; alu_class = cls; alu_carry = c; alu_branch = b;
  endtask

  task automatic t_reset();
    chk("R1 ccr", ccr_q, 4'b0000);
    chk("R12 irq", {3'b0, irq_allow}, 4'b0000);
  endtask

  task automatic t_arith();
    alu(2'b00, 1, 0); step(); chk("R3 arith c", ccr_q, 4'b0001);
    alu(2'b00, 0, 1); step(); chk("R3 arith b", ccr_q, 4'b0010);
  endtask

  task automatic t_logic();
    alu(2'b00, 1, 0); step();
    alu(2'b01, 0, 1); step(); chk("R4 logic", ccr_q, 4'b0011);
  endtask

  task automatic t_shift();
    alu(2'b10, 0, 0); step(); chk("R5 shift clr", ccr_q, 4'b0000);
    chk("R5 shift carry out", {3'b0, shift_carry_in}, 4'b0000);
    alu(2'b10, 1, 1); step(); chk("R5 shift set", ccr_q, 4'b0011);
    chk("R5 shift carry out", {3'b0, shift_carry_in}, 4'b0001);
  endtask

  task automatic t_idle();
    alu(2'b11, 0, 0); step(); chk("R6 class none", ccr_q, 4'b0011);
    alu(2'b00, 0, 0); alu_valid = 0; step(); chk("R6 not valid", ccr_q, 4'b0011);
  endtask

  task automatic t_set_bc();
    cmd_load = 1; load_data = 4'b0000; step();
    cmd_set_bc = 1; alu(2'b00, 0, 0); step(); chk("R7 set_bc over alu", ccr_q, 4'b0011);
  endtask

  task automatic t_toggle();
    cmd_tog_b = 1; alu(2'b00, 0, 1); step(); chk("R8 toggle with alu", ccr_q, 4'b0000);
    cmd_tog_b = 1; step(); chk("R8 toggle alone", ccr_q, 4'b0010);
    cmd_set_bc = 1; cmd_tog_b = 1; step(); chk("R13 set beats toggle", ccr_q, 4'b0011);
  endtask

  task automatic t_load();
    cmd_load = 1; load_data = 4'b1100; cmd_set_bc = 1; cmd_di = 1; alu(2'b10, 1, 1);
    step(); chk("R9 load wins", ccr_q, 4'b1000);
    chk("R12 irq", {3'b0, irq_allow}, 4'b0001);
    cmd_load = 1; load_data = 4'b1111; step(); chk("R2 reserved bit", ccr_q, 4'b1011);
  endtask

  task automatic t_irq();
    cmd_di = 1; cmd_ei = 1; cmd_sleep = 1; step(); chk("R10 di wins", ccr_q, 4'b0011);
    chk("R12 irq off", {3'b0, irq_allow}, 4'b0000);
    cmd_set_bc = 1; cmd_tog_b = 1; alu(2'b00, 0, 0); step();
    chk("R11 no ie from others", ccr_q, 4'b0011);
    cmd_ei = 1; step(); chk("R11 ei sets", ccr_q, 4'b1011);
    cmd_di = 1; step(); chk("R10 di clears", ccr_q, 4'b0011);
    cmd_sleep = 1; step(); chk("R11 sleep sets", ccr_q, 4'b1011);
    chk("R12 irq on", {3'b0, irq_allow}, 4'b0001);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_idle();
    t_set_bc();
    t_toggle();
    t_load();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule